// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces the frequency-offset word that a fractional-N synthesizer adds to its divide ratio to spread the output spectrum. A triangular profile runs between an upper and a lower limit and repeats every 512 reference-clock cycles, so the modulation rate is the reference frequency divided by 512. The block only computes the offset sequence over time. It has no analog content.

The limits are set by a shape select and a magnitude code. Centered shapes swing evenly about nominal. Downward shapes only lower the frequency. Asymmetric shapes have a small positive peak and a larger negative trough. The offset is a signed word in units of 1/64 percent. A strobe marks each cycle in which that word moves to a new value. A change of shape or magnitude is held off until the current period ends. The enable input forces the offset back to zero at once.

Top module: `ssm_profile_gen`

## Requirements
- R1: While `rst` is high, `offset_o` is 0 and `step_o` is 0.
- R2: The cycle after `spread_en` is sampled low, `offset_o` is 0, and it stays 0 while the enable stays low. Shape code 2'b00, or magnitude code 0 with any shape, also gives an offset of 0 in every cycle.
- R3: The phase is the number of clock edges since the first edge at which `spread_en` was sampled high. The profile repeats with a period of 512 cycles, and each period restarts at phase 0 with the starting value of the selected shape.
- R4: Shape 2'b01 (centered) with magnitude m has limits +8m and -8m. The offset is 0 at phase 0, falls to -8m at phase 128, rises to +8m at phase 384, then falls again.
- R5: Shape 2'b10 (downward) with magnitude m has limits 0 and -16m. The offset starts at 0, reaches -16m at phase 256, and never goes above 0.
- R6: Shape 2'b11 (asymmetric) with magnitude m has upper limit U = 8*(1 + floor(m/4)) and lower limit U - 16*(m+4). The offset starts at U, which is positive, and reaches the lower limit at phase 256.
- R7: At every phase p the offset is the floor of the exact linear value. That exact value moves by span/256 per cycle, where span is the upper limit minus the lower limit. The offset always stays inside the two limits.
- R8: A change of shape or magnitude while enabled takes effect at phase 0 of the next period. The rest of the current period follows the old setting.
- R9: `step_o` is high exactly in the cycles where `offset_o` differs from its value in the cycle before.
- R10: Between restarts the offset changes by at most 2 units per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_en | input | 1 | Spreading enable; low forces a zero offset |
| shape_sel | input | 2 | 00 off, 01 centered, 10 downward, 11 asymmetric |
| mag_sel | input | 4 | Magnitude code |
| offset_o | output | OFS_W (10) | Signed offset, 1/64 percent per unit |
| step_o | output | 1 | High in cycles where the offset took a new value |

## Verification
All inputs are sampled at a rising edge, and every result appears on the outputs one edge later. The first edge with the enable high loads the setting and shows the phase 0 value. Each later edge advances the phase by one. A setting change appears one edge after the phase 511 cycle, and a cleared enable zeroes the offset on the following edge. The bench drives and samples on falling edges and tracks the phase itself from the edge at which it raised the enable. It computes each expected value from the closed-form limit and slope formulas. The strobe is compared with whether the sampled offset differs from the one sampled a cycle earlier.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int SSM_MAG_W     = 4;
    localparam int SSM_EIGHTH    = 8;  // 0.125 percent in 1/64 percent units
    localparam int SSM_ASYM_BASE = 4;  // extra span codes on the asymmetric shape

    typedef enum logic [1:0] {
        SHAPE_OFF    = 2'b00,
        SHAPE_CENTER = 2'b01,
        SHAPE_DOWN   = 2'b10,
        SHAPE_ASYM   = 2'b11
    } shape_e;

    typedef struct packed {
        shape_e                 shape;
        logic [SSM_MAG_W-1:0]   mag;
    } cfg_t;

    localparam cfg_t CFG_IDLE = '{shape: SHAPE_OFF, mag: '0};

    function automatic int upper_of(shape_e s, logic [SSM_MAG_W-1:0] m);
        int mi;
        mi = int'(m);
        if (mi == 0) return 0;
        case (s)
            SHAPE_CENTER: return SSM_EIGHTH * mi;
            SHAPE_ASYM:   return SSM_EIGHTH * (1 + mi / 4);
            default:      return 0;
        endcase
    endfunction

    function automatic int lower_of(shape_e s, logic [SSM_MAG_W-1:0] m);
        int mi;
        mi = int'(m);
        if (mi == 0) return 0;
        case (s)
            SHAPE_CENTER: return -SSM_EIGHTH * mi;
            SHAPE_DOWN:   return -2 * SSM_EIGHTH * mi;
            SHAPE_ASYM:   return upper_of(s, m) - 2 * SSM_EIGHTH * (mi + SSM_ASYM_BASE);
            default:      return 0;
        endcase
    endfunction

    function automatic int start_of(shape_e s, logic [SSM_MAG_W-1:0] m);
        if (s == SHAPE_CENTER) return 0;
        return upper_of(s, m);
    endfunction

endpackage

// File: rtl/ssm_limits.sv
module ssm_limits
    import ssm_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  shape_e                      shape_i,
    input  logic [SSM_MAG_W-1:0]        mag_i,
    output logic signed [OFS_W-1:0]     upper_o,
    output logic signed [OFS_W-1:0]     lower_o,
    output logic [OFS_W-1:0]            span_o,
    output logic                        centered_o
);

    always_comb begin
        int u;
        int l;
        u          = upper_of(shape_i, mag_i);
        l          = lower_of(shape_i, mag_i);
        upper_o    = OFS_W'(u);
        lower_o    = OFS_W'(l);
        span_o     = OFS_W'(u - l);
        centered_o = (shape_i == SHAPE_CENTER);
    end

endmodule

// File: rtl/ssm_dir_sched.sv
module ssm_dir_sched #(
    parameter int PHASE_W = 9
) (
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               centered_i,
    output logic               go_up_o
);

    localparam logic [PHASE_W-1:0] QTR   = PHASE_W'(2 ** (PHASE_W - 2));
    localparam logic [PHASE_W-1:0] HALF  = PHASE_W'(2 ** (PHASE_W - 1));
    localparam logic [PHASE_W-1:0] QTR3  = PHASE_W'(3 * 2 ** (PHASE_W - 2));

    always_comb begin
        if (centered_i) go_up_o = (phase_i >= QTR) && (phase_i < QTR3);
        else            go_up_o = (phase_i >= HALF);
    end

endmodule

// File: rtl/ssm_ramp.sv
module ssm_ramp
    import ssm_pkg::*;
#(
    parameter int PHASE_W = 9,
    parameter int OFS_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  cfg_t                     cfg_i,
    input  logic [OFS_W-1:0]         span_i,
    input  logic                     go_up_i,
    output logic [PHASE_W-1:0]       phase_o,
    output cfg_t                     cfg_o,
    output logic signed [OFS_W-1:0]  offset_o,
    output logic                     step_o,
    output logic                     restart_o
);

    localparam int FRAC_W = PHASE_W - 1;
    localparam int ACC_W  = OFS_W + FRAC_W;
    localparam logic [PHASE_W-1:0] LAST = '1;

    typedef struct packed {
        logic               active;
        logic [PHASE_W-1:0] phase;
        cfg_t               cfg;
        logic [ACC_W-1:0]   acc;
        logic               step;
    } ramp_st_t;

    ramp_st_t         st_d;
    ramp_st_t         st_q;
    logic [OFS_W-1:0] start_w;
    logic [ACC_W-1:0] span_ext;

    assign start_w  = OFS_W'(start_of(cfg_i.shape, cfg_i.mag));
    assign span_ext = {{FRAC_W{1'b0}}, span_i};

    always_comb begin
        st_d      = st_q;
        restart_o = 1'b0;
        if (!en_i) begin
            st_d.active = 1'b0;
            st_d.phase  = '0;
            st_d.cfg    = CFG_IDLE;
            st_d.acc    = '0;
        end else if (!st_q.active || (st_q.phase == LAST)) begin
            restart_o   = 1'b1;
            st_d.active = 1'b1;
            st_d.phase  = '0;
            st_d.cfg    = cfg_i;
            st_d.acc    = {start_w, {FRAC_W{1'b0}}};
        end else begin
            st_d.phase  = st_q.phase + 1'b1;
            st_d.acc    = go_up_i ? (st_q.acc + span_ext) : (st_q.acc - span_ext);
        end
        st_d.step = (st_d.acc[ACC_W-1:FRAC_W] != st_q.acc[ACC_W-1:FRAC_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b0;
            st_q.phase  <= '0;
            st_q.cfg    <= CFG_IDLE;
            st_q.acc    <= '0;
            st_q.step   <= 1'b0;
        end else begin
            st_q        <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign cfg_o    = st_q.cfg;
    assign offset_o = st_q.acc[ACC_W-1:FRAC_W];
    assign step_o   = st_q.step;

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int PHASE_W = 9,
    parameter int OFS_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     spread_en,
    input  logic [1:0]               shape_sel,
    input  logic [SSM_MAG_W-1:0]     mag_sel,
    output logic signed [OFS_W-1:0]  offset_o,
    output logic                     step_o
);

    cfg_t                    cfg_in;
    cfg_t                    cfg_q;
    logic [PHASE_W-1:0]      phase_q;
    logic signed [OFS_W-1:0] lim_upper;
    logic signed [OFS_W-1:0] lim_lower;
    logic [OFS_W-1:0]        lim_span;
    logic                    lim_centered;
    logic                    go_up;
    logic                    restart;

    assign cfg_in.shape = shape_e'(shape_sel);
    assign cfg_in.mag   = mag_sel;

    ssm_limits #(.OFS_W(OFS_W)) u_lim (
        .shape_i    (cfg_q.shape),
        .mag_i      (cfg_q.mag),
        .upper_o    (lim_upper),
        .lower_o    (lim_lower),
        .span_o     (lim_span),
        .centered_o (lim_centered)
    );

    ssm_dir_sched #(.PHASE_W(PHASE_W)) u_dir (
        .phase_i    (phase_q),
        .centered_i (lim_centered),
        .go_up_o    (go_up)
    );

    ssm_ramp #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .en_i      (spread_en),
        .cfg_i     (cfg_in),
        .span_i    (lim_span),
        .go_up_i   (go_up),
        .phase_o   (phase_q),
        .cfg_o     (cfg_q),
        .offset_o  (offset_o),
        .step_o    (step_o),
        .restart_o (restart)
    );

endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk #(
    parameter int PHASE_W = 9,
    parameter int OFS_W   = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     spread_en,
    input logic signed [OFS_W-1:0]  offset_o,
    input logic                     step_o,
    input logic                     restart,
    input logic [PHASE_W-1:0]       phase_q,
    input logic [1:0]               cfg_shape,
    input logic [3:0]               cfg_mag,
    input logic signed [OFS_W-1:0]  lim_upper,
    input logic signed [OFS_W-1:0]  lim_lower
);

    p_disable_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !spread_en |=> (offset_o == 0));

    p_restart_phase_r3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == 0));

    p_down_nonpos_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_shape == 2'b10) |-> (offset_o <= 0));

    p_asym_start_r6: assert property (@(posedge clk) disable iff (rst)
        ((cfg_shape == 2'b11) && (cfg_mag != 0) && (phase_q == 0)) |-> (offset_o > 0));

    p_within_limits_r7: assert property (@(posedge clk) disable iff (rst)
        (offset_o >= lim_lower) && (offset_o <= lim_upper));

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(spread_en) && !$past(restart)) |-> ($stable(cfg_shape) && $stable(cfg_mag)));

    p_step_change_r9: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (offset_o != $past(offset_o)));

    p_hold_nostep_r9: assert property (@(posedge clk) disable iff (rst)
        !step_o |-> (offset_o == $past(offset_o)));

    p_slope_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(spread_en) && !$past(restart)) |->
            ((offset_o - $past(offset_o) <= 2) && (offset_o - $past(offset_o) >= -2)));

endmodule

bind ssm_profile_gen ssm_profile_chk #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .spread_en (spread_en),
    .offset_o  (offset_o),
    .step_o    (step_o),
    .restart   (restart),
    .phase_q   (phase_q),
    .cfg_shape (cfg_q.shape),
    .cfg_mag   (cfg_q.mag),
    .lim_upper (lim_upper),
    .lim_lower (lim_lower)
);

// File: tb/ssm_profile_gen_tb.sv
`timescale 1ns/1ps
module ssm_profile_gen_tb;

    localparam int PHASE_W = 9;
    localparam int OFS_W   = 10;
    localparam int PERIOD  = 2 ** PHASE_W;
    localparam int FRAC    = PHASE_W - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    spread_en = 1'b0;
    logic [1:0]              shape_sel = 2'b00;
    logic [3:0]              mag_sel = 4'd0;
    logic signed [OFS_W-1:0] offset_o;
    logic                    step_o;

    int checks = 0;
    int errors = 0;
    int prev   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ssm_profile_gen #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .spread_en (spread_en),
        .shape_sel (shape_sel),
        .mag_sel   (mag_sel),
        .offset_o  (offset_o),
        .step_o    (step_o)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int up_lim(int sh, int m);
        if (m == 0) return 0;
        if (sh == 1) return 8 * m;
        if (sh == 3) return 8 * (1 + m / 4);
        return 0;
    endfunction

    function automatic int lo_lim(int sh, int m);
        if (m == 0) return 0;
        if (sh == 1) return -8 * m;
        if (sh == 2) return -16 * m;
        if (sh == 3) return up_lim(sh, m) - 16 * (m + 4);
        return 0;
    endfunction

    function automatic int exp_ofs(int sh, int m, int p);
        int span;
        int a;
        span = up_lim(sh, m) - lo_lim(sh, m);
        if (sh == 1) begin
            if (p <= PERIOD / 4)          a = -p * span;
            else if (p <= 3 * PERIOD / 4) a = -(PERIOD / 4) * span + (p - PERIOD / 4) * span;
            else                          a = up_lim(sh, m) * (PERIOD / 2) - (p - 3 * PERIOD / 4) * span;
        end else begin
            if (p <= PERIOD / 2) a = up_lim(sh, m) * (PERIOD / 2) - p * span;
            else                 a = lo_lim(sh, m) * (PERIOD / 2) + (p - PERIOD / 2) * span;
        end
        return a >>> FRAC;
    endfunction

    task automatic sample(int exp, string req);
        int act;
        @(negedge clk);
        act = int'(offset_o);
        check(act == exp, req, act, exp);
        check(step_o == (act != prev), "R9 step strobe", int'(step_o), int'(act != prev));
        prev = act;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(offset_o == 0, "R1 reset offset", int'(offset_o), 0);
        check(step_o == 1'b0, "R1 reset strobe", int'(step_o), 0);
        rst = 1'b0;

        // R2: shape code off gives zero
        shape_sel = 2'b00; mag_sel = 4'd5; spread_en = 1'b1;
        for (int i = 0; i < 20; i++) sample(0, "R2 shape off");
        spread_en = 1'b0;
        sample(0, "R2 disabled");

        // R3 R4 R5 R6 R7: sweep every shape and magnitude over one period plus wrap
        for (int sh = 1; sh <= 3; sh++) begin
            for (int m = 0; m < 16; m++) begin
                shape_sel = 2'(sh); mag_sel = 4'(m); spread_en = 1'b1;
                for (int i = 0; i <= PERIOD; i++) begin
                    if (sh == 1)      sample(exp_ofs(sh, m, i % PERIOD), "R3 R4 R7 centered");
                    else if (sh == 2) sample(exp_ofs(sh, m, i % PERIOD), "R3 R5 R7 downward");
                    else              sample(exp_ofs(sh, m, i % PERIOD), "R3 R6 R7 asymmetric");
                end
                spread_en = 1'b0;
                sample(0, "R2 disable after sweep");
            end
        end

        // R8: setting change mid-period waits for the next period
        shape_sel = 2'b01; mag_sel = 4'd4; spread_en = 1'b1;
        for (int i = 0; i < PERIOD; i++) begin
            sample(exp_ofs(1, 4, i), "R8 old setting held");
            if (i == 200) begin
                shape_sel = 2'b10; mag_sel = 4'd8;
            end
        end
        for (int i = 0; i < PERIOD; i++) sample(exp_ofs(2, 8, i), "R8 new setting");

        // R2: disable mid-period clears at once; R3: restart on re-enable
        for (int i = 0; i < 100; i++) sample(exp_ofs(2, 8, i), "R10 R5 third period");
        spread_en = 1'b0;
        sample(0, "R2 disable mid-period");
        sample(0, "R2 disable held");
        shape_sel = 2'b01; mag_sel = 4'd15; spread_en = 1'b1;
        for (int i = 0; i < 140; i++) sample(exp_ofs(1, 15, i), "R3 restart R10 slope");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule